// File: doc/BRIEF.md
# Variable-Rate Sample Strobe Generator

This block produces a sample-enable strobe at a programmable average rate while running from one fixed clock. A phase accumulator of `ACC_W` bits adds a tuning word every cycle; each time the sum carries out past the top of the range, a one-cycle strobe is issued. The average strobe frequency is f_clk × tune / 2^ACC_W. Single intervals between strobes vary by at most one cycle, and only the long-run rate is exact.

The strobe also clocks a binary divider with `DIV_STAGES + 1` bits. A tap select picks one divider bit as a slower level output whose relative jitter shrinks with each stage. A one-cycle pulse marks every rising edge of that bit. Downstream logic uses the strobe or the pulse as a clock enable to sample an input or start an action. The tuning word may change at any time without disturbing the running phase.

Top module: `nco_strobe_gen`

## Requirements
- R1: On every clock edge out of reset, the accumulator takes the sum of its value and the registered tuning word, modulo 2^ACC_W. `strobe_o` is high for exactly the one cycle after each edge whose sum carried out, and is low otherwise.
- R2: Starting from a cleared accumulator with a constant tuning word t, the strobe count over 2^ACC_W / g cycles equals t / g, where g = gcd(t, 2^ACC_W). This also holds for the largest tuning word, 2^ACC_W − 1.
- R3: A tuning word of zero produces no strobes.
- R4: `tune_i` is captured at one edge and first added at the next edge. A change of the word keeps the accumulated phase and does not reset it.
- R5: With a constant nonzero word t, every interval between consecutive strobes is floor(2^ACC_W / t) or ceil(2^ACC_W / t) cycles.
- R6: The divider counter advances by one, modulo 2^(DIV_STAGES+1), at the edge after each cycle in which `strobe_o` is high, and holds otherwise.
- R7: `smooth_o` equals divider bit `tap_sel_i` (bit 0 toggles on every strobe). A select value above DIV_STAGES acts as DIV_STAGES.
- R8: `edge_pulse_o` is high for one cycle, starting the edge after each cycle in which the selected bit is 1 and was 0 in the cycle before.
- R9: While `rst` is high at an edge, the accumulator, the divider, the strobe and the edge pulse are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency system clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_i | input | ACC_W | Tuning increment added per cycle |
| tap_sel_i | input | $clog2(DIV_STAGES+1) | Divider bit driving the smoothed output |
| strobe_o | output | 1 | One-cycle wrap strobe |
| smooth_o | output | 1 | Selected divider bit |
| edge_pulse_o | output | 1 | One-cycle pulse on each rising edge of the selected bit |

## Verification
A new tuning word reaches the adder one edge after it is driven, and its first effect on `strobe_o` appears one edge after that. The divider steps one edge after a strobe is seen. `smooth_o` follows the tap select without delay, and the edge pulse lags the selected bit by one edge. The bench's reference model steps at every rising edge with the same latencies. It compares all three outputs 2 ns after the edge, while inputs only change on falling edges. Separate checks count strobes over whole gcd windows, measure intervals, and test the phase-keeping edge when the word changes.

// File: rtl/nco_pkg.sv
package nco_pkg;
   // limit a tap request to the highest divider bit
   function automatic int unsigned tap_limit(input int unsigned req, input int unsigned top);
      return (req > top) ? top : req;
   endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] tune_i,
   output logic [ACC_W-1:0] tune_q,
   output logic [ACC_W-1:0] acc_q,
   output logic             wrap_q
);
   localparam int unsigned SUM_W = ACC_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, acc_q} + {1'b0, tune_q};

   // shadow of the tuning word: loads every edge, used one edge later
   always_ff @(posedge clk) begin
      tune_q <= tune_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         acc_q  <= sum[ACC_W-1:0];
         wrap_q <= sum[ACC_W];
      end
   end
endmodule

// File: rtl/nco_wrap_divider.sv
module nco_wrap_divider #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/nco_tap_edge.sv
module nco_tap_edge #(
   parameter int unsigned CNT_W = 9,
   parameter int unsigned TAP_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [TAP_W-1:0] tap_sel_i,
   output logic             level_o,
   output logic             pulse_q
);
   import nco_pkg::*;

   localparam int unsigned TOP = CNT_W - 1;

   logic [CNT_W-1:0] tap_hot;
   logic             prev_q;

   // one-hot decode of the clamped tap, one lane per divider bit
   for (genvar b = 0; b < CNT_W; b++) begin : g_lane
      assign tap_hot[b] = (tap_limit(int'(tap_sel_i), TOP) == b);
   end

   assign level_o = |(tap_hot & cnt_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         prev_q  <= level_o;
         pulse_q <= level_o & ~prev_q;
      end
   end
endmodule

// File: rtl/nco_strobe_gen.sv
module nco_strobe_gen #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned DIV_STAGES = 8,
   localparam int unsigned CNT_W     = DIV_STAGES + 1,
   localparam int unsigned TAP_W     = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] tune_i,
   input  logic [TAP_W-1:0] tap_sel_i,
   output logic             strobe_o,
   output logic             smooth_o,
   output logic             edge_pulse_o
);
   if (ACC_W < 2 || ACC_W > 64) begin : g_bad_acc
      $error("nco_strobe_gen: ACC_W must lie in 2..64");
   end
   if (DIV_STAGES < 1 || DIV_STAGES > 31) begin : g_bad_div
      $error("nco_strobe_gen: DIV_STAGES must lie in 1..31");
   end

   logic [ACC_W-1:0] tune_q;
   logic [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0] div_cnt;

   nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .tune_i(tune_i),
      .tune_q(tune_q),
      .acc_q (acc_q),
      .wrap_q(strobe_o)
   );

   nco_wrap_divider #(.CNT_W(CNT_W)) u_div (
      .clk   (clk),
      .rst   (rst),
      .step_i(strobe_o),
      .cnt_q (div_cnt)
   );

   nco_tap_edge #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_tap (
      .clk      (clk),
      .rst      (rst),
      .cnt_i    (div_cnt),
      .tap_sel_i(tap_sel_i),
      .level_o  (smooth_o),
      .pulse_q  (edge_pulse_o)
   );
endmodule

// File: rtl/nco_strobe_gen_chk.sv
module nco_strobe_gen_chk #(
   parameter int unsigned ACC_W = 32,
   parameter int unsigned CNT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic [ACC_W-1:0] tune_i,
   input logic [ACC_W-1:0] tune_q,
   input logic [ACC_W-1:0] acc_q,
   input logic             strobe_o,
   input logic [CNT_W-1:0] div_cnt,
   input logic             pulse_o
);
   // a carry leaves the phase below where it was
   p_wrap_strobe_r1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (strobe_o == (acc_q < $past(acc_q))));

   p_zero_silent_r3: assert property (@(posedge clk) disable iff (rst)
      (tune_q == '0) |=> !strobe_o);

   p_tune_shadow_r4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (tune_q == $past(tune_i)));

   p_div_step_r6: assert property (@(posedge clk) disable iff (rst)
      strobe_o |=> (div_cnt == $past(div_cnt) + CNT_W'(1)));

   p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !strobe_o |=> $stable(div_cnt));

   p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (!strobe_o && !pulse_o && acc_q == '0 && div_cnt == '0));
endmodule

bind nco_strobe_gen nco_strobe_gen_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .tune_i  (tune_i),
   .tune_q  (tune_q),
   .acc_q   (acc_q),
   .strobe_o(strobe_o),
   .div_cnt (div_cnt),
   .pulse_o (edge_pulse_o)
);

// File: tb/nco_strobe_gen_tb.sv
`timescale 1ns/1ps
module nco_strobe_gen_tb;
   localparam int unsigned ACC_W = 16;
   localparam int unsigned DIVS  = 6;
   localparam int unsigned TAPW  = 3;
   localparam longint      MODV  = 64'd1 << ACC_W;
   localparam longint      CMASK = (64'd1 << (DIVS + 1)) - 1;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [ACC_W-1:0] tune_i = '0;
   logic [TAPW-1:0]  tap_sel_i = '0;
   logic             strobe_o, smooth_o, edge_pulse_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   nco_strobe_gen #(.ACC_W(ACC_W), .DIV_STAGES(DIVS)) u_dut (
      .clk(clk), .rst(rst), .tune_i(tune_i), .tap_sel_i(tap_sel_i),
      .strobe_o(strobe_o), .smooth_o(smooth_o), .edge_pulse_o(edge_pulse_o)
   );

   // behavioural reference
   longint m_acc = 0, m_tune = 0, m_cnt = 0;
   bit     m_strobe = 0, m_prev = 0, m_pulse = 0;

   // strobe bookkeeping for window and interval checks
   longint cyc = 0, last_stb = -1;
   int     stb_count = 0;
   bit     iv_bad = 0;
   longint iv_seen = 0;
   longint iv_lo = 0, iv_hi = 0;
   bit     iv_on = 0;

   function automatic int tapc(input int s);
      return (s > DIVS) ? DIVS : s;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      longint sum, ncnt;
      bit     sel, nstb;
      sel  = ((m_cnt >> tapc(int'(tap_sel_i))) & 1) != 0;
      sum  = m_acc + m_tune;
      nstb = (sum >= MODV);
      ncnt = (m_cnt + (m_strobe ? 1 : 0)) & CMASK;
      if (rst) begin
         m_acc = 0; m_cnt = 0; m_strobe = 0; m_prev = 0; m_pulse = 0;
      end else begin
         m_pulse  = sel & ~m_prev;
         m_prev   = sel;
         m_cnt    = ncnt;
         m_acc    = sum % MODV;
         m_strobe = nstb;
      end
      m_tune = longint'(tune_i);
      #2;
      cyc++;
      check(strobe_o == m_strobe, "R1 strobe", strobe_o, m_strobe);
      check(smooth_o == (((m_cnt >> tapc(int'(tap_sel_i))) & 1) != 0), "R7 smooth", smooth_o,
            (m_cnt >> tapc(int'(tap_sel_i))) & 1);
      check(edge_pulse_o == m_pulse, "R8 edge pulse", edge_pulse_o, m_pulse);
      if (strobe_o) begin
         stb_count++;
         if (iv_on && last_stb >= 0) begin
            iv_seen++;
            if ((cyc - last_stb) != iv_lo && (cyc - last_stb) != iv_hi) iv_bad = 1;
         end
         last_stb = cyc;
      end
   end

   // reset with word t held, release, count strobes over w cycles
   task automatic window(input longint t, input longint w, input longint expc, input int tap);
      @(negedge clk);
      rst = 1'b1; tune_i = ACC_W'(t); tap_sel_i = TAPW'(tap);
      repeat (2) @(negedge clk);
      check(strobe_o == 0 && edge_pulse_o == 0 && smooth_o == 0, "R9 reset clear",
            {strobe_o, edge_pulse_o, smooth_o}, 0);
      iv_on = (t != 0);
      iv_lo = (t != 0) ? MODV / t : 0;
      iv_hi = (t != 0) ? iv_lo + ((MODV % t) != 0 ? 1 : 0) : 0;
      iv_bad = 0; iv_seen = 0; last_stb = -1;
      rst = 1'b0;
      stb_count = 0;
      repeat (w) @(posedge clk);
      #3;
      if (t == 0) check(stb_count == 0, "R3 zero word", stb_count, 0);
      else        check(stb_count == expc, "R2 window count", stb_count, expc);
      if (t != 0) check(!iv_bad, "R5 interval spread", iv_bad, 0);
      iv_on = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      window(64'h8000, 2,     1,     0);
      window(64'h0300, 256,   3,     2);
      window(64'd1000, 8192,  125,   1);
      window(64'hFFFF, 65536, 65535, 7);   // select 7 clamps to bit 6
      window(64'h0000, 1000,  0,     3);
      window(64'h0100, 4096,  16,    0);
      // R4: phase kept across a word change
      @(negedge clk);
      rst = 1'b1; tune_i = 16'h4000; tap_sel_i = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);            // edge 1: acc 0x4000
      @(negedge clk);            // edge 2: acc 0x8000
      tune_i = 16'h8000;
      @(posedge clk); #2;        // edge 3: old word added, acc 0xC000
      check(strobe_o == 0, "R4 old word still used", strobe_o, 0);
      @(posedge clk); #2;        // edge 4: 0xC000 + 0x8000 carries
      check(strobe_o == 1, "R4 phase kept", strobe_o, 1);
      @(posedge clk); #2;        // edge 5: acc 0xC000, no carry
      check(strobe_o == 0, "R4 new rate", strobe_o, 0);
      // R6: bit 0 toggles once per strobe, seen at the smoothed output
      tap_sel_i = '0;
      repeat (200) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (150000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule